// File: doc/BRIEF.md
# Programmable Interval Timer Channel with Shared Prescaler

This block is one interval-timer channel of a sound and I/O peripheral, clocked by the CPU cycle clock. Two free-running dividers form a shared prescaler. One gives a slow tick every 28 cycles and the other gives a line-rate tick every 114 cycles. A down-counter steps on the selected source. It is reloaded from an 8-bit period value, and on every underflow it may raise a sticky interrupt request.

Software talks to the block through a simple write port with five addresses. Address 0 is the clock-source select. Address 1 holds the period value. Address 2 is the interrupt enable. A write to address 3 is a restart strobe, and address 4 is the prescaler run/hold control. The restart strobe reloads the counter but leaves the prescaler phase alone. Because of that, software can set the phase of the base ticks only with the hold-then-release sequence on address 4. Four slow ticks take 112 cycles and a display line takes 114, so a timer on the slow tick slides 2 cycles earlier on each line.

Top module: `snd_interval_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `irq_pending` is 0. The interrupt enable and the period value reset to 0, the clock select resets to the 28-cycle tick, and the prescaler resets to running.
- R2: A write of 0 to address 4 holds both prescaler dividers at zero, and no base tick occurs while they are held. A later write with either of bits [1:0] set releases them. The first 28-cycle tick then lands 28 cycles after the releasing write edge, and the first 114-cycle tick lands 114 cycles after it.
- R3: With bits 0 and 6 of address 0 both clear, the counter steps on the 28-cycle tick. With period value P (address 1), consecutive underflows are (P+1)*28 cycles apart. For P=15 this is 448 cycles.
- R4: With bit 0 of address 0 set and bit 6 clear, the counter steps on the 114-cycle tick, and underflows are (P+1)*114 cycles apart. For P=3 this is 456 cycles.
- R5: With bit 6 of address 0 set, the counter steps every cycle and carries a fixed reload overhead. Underflows are P+4 cycles apart, and the first one comes P+4 cycles after a restart strobe.
- R6: A write to address 3 (any data) loads the counter from the period value at that edge and does not touch the prescaler. The first decrement waits for the next base tick after the write, so with P=1 the first underflow lands on the second base tick after the strobe.
- R7: With the 28-cycle tick and P=3, underflows are 112 cycles apart. Each one therefore falls 2 cycles earlier, modulo 114, than the one before.
- R8: `irq_pending` goes high at the same clock edge as an underflow that occurs while bit 0 of address 2 is 1. It then stays high until address 2 is written with bit 0 clear, which clears it at that edge. Writes to other addresses leave it set.
- R9: An underflow while the enable bit is 0 still reloads the counter but leaves `irq_pending` low. Later underflows therefore keep their original spacing once the enable bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address (0 select, 1 period, 2 enable, 3 restart, 4 run/hold) |
| wr_data | input | 8 | Write data |
| irq_pending | output | 1 | Registered, sticky timer interrupt request |

## Verification
On every cycle, the assertions check the following local rules. A held divider produces no tick. The counter keeps its value unless it is stepped or restarted, and it takes the reload value after an underflow. The pending flag only rises on an enabled underflow, is cleared by a disabling write and is otherwise held, and is never set while the enable is off. The bench scenarios are the only way to show the absolute timing. That covers the phase of the first tick after release, the full periods in all three clock modes, the fixed fast-mode overhead, and the way a restart keeps the old prescaler phase. It also covers the 2-cycle drift against the line and the continued reloads while the interrupt is masked.

// File: rtl/snd_tmr_pkg.sv
`timescale 1ns/1ps
package snd_tmr_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CLKSEL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] A_IRQEN  = 3'd2;
  localparam logic [ADDR_W-1:0] A_START  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RUN    = 3'd4;
  localparam int SEL_LINE_BIT = 0;
  localparam int SEL_FAST_BIT = 6;

  typedef struct packed {
    logic fast;
    logic line;
  } clk_sel_t;
endpackage

// File: rtl/snd_tmr_divider.sv
`timescale 1ns/1ps
module snd_tmr_divider #(
  parameter int DIV = 28
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || !run)          phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign tick = run && (phase_q == LAST);

  // R2
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase_q == '0));

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/snd_tmr_downcount.sv
`timescale 1ns/1ps
module snd_tmr_downcount #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          start,
  input  logic [CW-1:0] reload,
  output logic          underflow
);
  logic [CW-1:0] count_q;

  assign underflow = step && !start && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                  count_q <= '0;
    else if (start)           count_q <= reload;
    else if (step) begin
      if (count_q == '0)      count_q <= reload;
      else                    count_q <= count_q - 1'b1;
    end
  end

  // R3
  reload_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |=> (count_q == $past(reload)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !start) |=> $stable(count_q));
endmodule

// File: rtl/snd_interval_timer.sv
`timescale 1ns/1ps
module snd_interval_timer
  import snd_tmr_pkg::*;
#(
  parameter int FREQ_W     = 8,
  parameter int DIV_MID    = 28,
  parameter int DIV_LINE   = 114,
  parameter int FAST_EXTRA = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [FREQ_W-1:0] wr_data,
  output logic              irq_pending
);
  localparam int CW = FREQ_W + 1;
  localparam logic [CW-1:0] EXTRA = CW'(FAST_EXTRA - 1);

  clk_sel_t          sel_q;
  logic [FREQ_W-1:0] period_q;
  logic              irq_en_q;
  logic              run_q;
  logic              pend_q;

  logic wr_sel, wr_period, wr_irqen, wr_run, start;
  assign wr_sel    = wr_en && (wr_addr == A_CLKSEL);
  assign wr_period = wr_en && (wr_addr == A_PERIOD);
  assign wr_irqen  = wr_en && (wr_addr == A_IRQEN);
  assign wr_run    = wr_en && (wr_addr == A_RUN);
  assign start     = wr_en && (wr_addr == A_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      period_q <= '0;
      irq_en_q <= 1'b0;
      run_q    <= 1'b1;
    end else begin
      if (wr_sel) begin
        sel_q.line <= wr_data[SEL_LINE_BIT];
        sel_q.fast <= wr_data[SEL_FAST_BIT];
      end
      if (wr_period) period_q <= wr_data;
      if (wr_irqen)  irq_en_q <= wr_data[0];
      if (wr_run)    run_q    <= |wr_data[1:0];
    end
  end

  logic tick_mid, tick_line;

  snd_tmr_divider #(.DIV(DIV_MID)) mid_div_i (
    .clk(clk), .rst(rst), .run(run_q), .tick(tick_mid));

  snd_tmr_divider #(.DIV(DIV_LINE)) line_div_i (
    .clk(clk), .rst(rst), .run(run_q), .tick(tick_line));

  logic          step, underflow;
  logic [CW-1:0] reload;

  always_comb begin
    if (sel_q.fast) begin
      step   = 1'b1;
      reload = {1'b0, period_q} + EXTRA;
    end else begin
      step   = sel_q.line ? tick_line : tick_mid;
      reload = {1'b0, period_q};
    end
  end

  snd_tmr_downcount #(.CW(CW)) cnt_i (
    .clk(clk), .rst(rst), .step(step), .start(start),
    .reload(reload), .underflow(underflow));

  always_ff @(posedge clk) begin
    if (rst)                          pend_q <= 1'b0;
    else if (wr_irqen && !wr_data[0]) pend_q <= 1'b0;
    else if (underflow && irq_en_q)   pend_q <= 1'b1;
  end

  assign irq_pending = pend_q;

  // R8
  pend_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pending) |-> $past(underflow && irq_en_q));

  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_irqen && !wr_data[0]) |=> !irq_pending);

  // R8
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_pending && !wr_irqen) |=> irq_pending);

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en_q |-> !irq_pending);
endmodule

// File: tb/snd_interval_timer_tb_top.sv
`timescale 1ns/1ps
module snd_interval_timer_tb_top;
  localparam logic [2:0] SEL = 3'd0, PER = 3'd1, IEN = 3'd2, STA = 3'd3, RUN = 3'd4;
  localparam int MID = 28, LINE = 114;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic irq_pending;
  int cyc = 0, n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  snd_interval_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_pending(irq_pending));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic init_seq(output int t);
    wr(RUN, 8'd0);
    repeat (3) @(negedge clk);
    wr(RUN, 8'd3);
    t = cyc;
  endtask

  task automatic wait_pend(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      if (irq_pending) begin at = cyc; break; end
      @(negedge clk);
    end
  endtask

  task automatic rearm();
    wr(IEN, 8'd0);
    wr(IEN, 8'd1);
  endtask

  task automatic t_reset();
    check(irq_pending == 1'b0, "R1 during reset", irq_pending, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(irq_pending == 1'b0, "R1 after reset", irq_pending, 0);
  endtask

  task automatic t_hold_release();
    int t, at; bit seen = 0;
    wr(SEL, 8'd0); wr(PER, 8'd0); wr(IEN, 8'd0);
    wr(RUN, 8'd0); wr(STA, 8'd0); wr(IEN, 8'd1);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); if (irq_pending) seen = 1;
    end
    check(!seen, "R2 no tick while held", seen, 0);
    wr(RUN, 8'd3); t = cyc;
    wait_pend(200, at);
    check(at == t + MID, "R2 first mid tick after release", at - t, MID);
  endtask

  task automatic t_period_mid();
    int a1, a2;
    wr(IEN, 8'd0); wr(PER, 8'd15); wr(STA, 8'd0); wr(IEN, 8'd1);
    wait_pend(1000, a1); rearm(); wait_pend(1000, a2);
    check(a1 > 0 && a2 - a1 == 448, "R3 mid period P=15", a2 - a1, 448);
    rearm();
  endtask

  task automatic t_start_phase();
    int t, s, k, at;
    wr(SEL, 8'd0); init_seq(t);
    wr(IEN, 8'd0); repeat (41) @(negedge clk);
    wr(PER, 8'd1); wr(STA, 8'd0); s = cyc; wr(IEN, 8'd1);
    k = (s - t) / MID + 1;
    wait_pend(500, at);
    check(at == t + MID * (k + 1), "R6 restart keeps prescaler phase", at, t + MID * (k + 1));
    rearm();
  endtask

  task automatic t_drift();
    int a1, a2;
    wr(IEN, 8'd0); wr(PER, 8'd3); wr(STA, 8'd0); wr(IEN, 8'd1);
    wait_pend(500, a1); rearm(); wait_pend(500, a2);
    check(a2 - a1 == 112, "R7 interval P=3", a2 - a1, 112);
    check((a2 % LINE) == ((a1 % LINE) + LINE - 2) % LINE, "R7 line drift -2",
          a2 % LINE, ((a1 % LINE) + LINE - 2) % LINE);
    rearm();
  endtask

  task automatic t_line();
    int t, a1, a2;
    wr(IEN, 8'd0); wr(SEL, 8'h01); wr(PER, 8'd3); wr(RUN, 8'd0);
    wr(STA, 8'd0); wr(IEN, 8'd1); wr(RUN, 8'd3); t = cyc;
    wait_pend(1000, a1);
    check(a1 == t + 4 * LINE, "R2 line tick phase from release", a1 - t, 4 * LINE);
    rearm(); wait_pend(1000, a2);
    check(a2 - a1 == 456, "R4 line period P=3", a2 - a1, 456);
    rearm();
  endtask

  task automatic t_fast();
    int s, a1, a2;
    wr(IEN, 8'd0); wr(SEL, 8'h40); wr(PER, 8'd10);
    wr(STA, 8'd0); s = cyc; wr(IEN, 8'd1);
    wait_pend(100, a1);
    check(a1 == s + 14, "R5 first fast underflow", a1 - s, 14);
    rearm(); wait_pend(100, a2);
    check(a2 - a1 == 14, "R5 fast period P+4", a2 - a1, 14);
    rearm();
  endtask

  task automatic t_sticky();
    int at;
    wr(IEN, 8'd0); wr(SEL, 8'd0); wr(PER, 8'd0); wr(STA, 8'd0); wr(IEN, 8'd1);
    wait_pend(100, at);
    check(at > 0, "R8 pending rises", at, 1);
    repeat (60) @(negedge clk);
    wr(PER, 8'd5);
    check(irq_pending == 1'b1, "R8 pending stays set", irq_pending, 1);
    wr(IEN, 8'd0);
    check(irq_pending == 1'b0, "R8 cleared by enable 0", irq_pending, 0);
  endtask

  task automatic t_masked();
    int t, s, e, k, at, exp; bit seen = 0;
    wr(SEL, 8'd0); wr(IEN, 8'd0); init_seq(t);
    wr(PER, 8'd2); wr(STA, 8'd0); s = cyc;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk); if (irq_pending) seen = 1;
    end
    check(!seen, "R9 masked underflow leaves pending low", seen, 0);
    wr(IEN, 8'd1); e = cyc;
    k = (s - t) / MID + 1 + 2;
    exp = t + MID * k;
    while (exp <= e) exp += 3 * MID;
    wait_pend(300, at);
    check(at == exp, "R9 reloads continued while masked", at, exp);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_hold_release();
    t_period_mid();
    t_start_phase();
    t_drift();
    t_line();
    t_fast();
    t_sticky();
    t_masked();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule